// File: doc/BRIEF.md
# Dithered Phase-Accumulator Sine/Cosine Synthesizer

This block produces a sampled complex sinusoid from a wide phase accumulator. On every sample strobe the accumulator advances by an integer step word, modulo 2^ACC_W. The output frequency is therefore the sample rate times the step word over 2^ACC_W, so one step unit is the finest frequency resolution. Before the accumulator is advanced, its current value is reduced to a narrow table address. The reduction rounds to the nearest address rather than truncating.

The rounding quantizer creates a periodic phase error, and that error shows up as spurs. To break that periodicity, a small pseudo-random offset can be added to the phase ahead of the quantizer. A quarter-wave sine table is built at elaboration time. Two lookups into it, a quarter turn apart, return a cosine word and a sine word for the same quantized phase. A valid pulse marks each new sample pair, two clocks after the strobe that produced it.

Top module: `dds_synth`

## Requirements
- R1: While reset is asserted and after it is released, before any strobe, `cos_out`, `sin_out` and `phase_out` are zero and `out_valid` is low.
- R2: Each clock with `sample_en` high adds `step_word` to the 32-bit accumulator, modulo 2^32. Clocks without `sample_en` leave the accumulator unchanged.
- R3: The sample for strobe n uses the accumulator value before step n is added. The first sample after reset therefore has phase 0, cosine 8191 and sine 0.
- R4: `phase_out` = ((acc + d + 2^19) mod 2^32) >> 20, where d is the dither term. This is rounding to nearest. A carry out of the top address wraps to address 0.
- R5: With `dither_en` low, d = 0. With `dither_en` high, d is the 16-bit LFSR state read as a signed number and multiplied by 4, so d lies in [-2^17, 2^17). The LFSR resets to 0xACE1. On every strobe, whatever the value of `dither_en`, it shifts left and takes in the XOR of bits 15, 13, 12 and 10.
- R6: For phase p, `cos_out` = round(8191·cos(2πp/4096)) and `sin_out` = round(8191·sin(2πp/4096)), with rounding half away from zero, as signed 14-bit values.
- R7: `out_valid` is high in exactly the clock that comes two clocks after each clock with `sample_en` high.
- R8: While `out_valid` is low, `cos_out`, `sin_out` and `phase_out` hold their previous values.
- R9: Neither output ever takes the code -8192.
- R10: A positive sine occurs only in the first half turn (`phase_out` MSB 0). A negative sine occurs only in the second half turn. A positive cosine occurs only when the two top phase bits are equal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_en | input | 1 | Sample strobe; advances the accumulator and the LFSR |
| step_word | input | 32 | Phase increment per sample |
| dither_en | input | 1 | Adds the pseudo-random offset ahead of rounding |
| cos_out | output | 14 | Signed cosine sample |
| sin_out | output | 14 | Signed sine sample |
| phase_out | output | 12 | Rounded phase address of the current sample |
| out_valid | output | 1 | New sample pair present |

## Verification
The following properties are checked on every clock by the assertions, whatever the stimulus:
- the two-clock valid latency;
- outputs holding between samples;
- the absence of the most negative code;
- the quadrant consistency between phase and output signs.

Other behaviours depend on arithmetic history, so only the bench's reference model and directed scenarios can show them:
- accumulator arithmetic and modulo wrap;
- the sample-before-step ordering;
- round-half-up and the wrap of the top address to zero;
- the LFSR dither sequence;
- the exact table values across all 4096 phases.

// File: rtl/dds_pkg.sv
package dds_pkg;
  localparam real TWO_PI = 6.283185307179586;

  // symmetric rounding of a real value to an integer
  function automatic int round_away(real x);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction
endpackage

// File: rtl/dds_lfsr.sv
module dds_lfsr #(
  parameter int              WIDTH = 16,
  parameter logic [WIDTH-1:0] TAPS = 16'hB400,
  parameter logic [WIDTH-1:0] SEED = 16'hACE1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             advance,
  output logic [WIDTH-1:0] state
);
  logic [WIDTH-1:0] state_d;

  always_comb begin
    state_d = state;
    if (advance) state_d = {state[WIDTH-2:0], ^(state & TAPS)};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= SEED;
    else        state <= state_d;
  end
endmodule

// File: rtl/dds_phase_quant.sv
module dds_phase_quant #(
  parameter int ACC_W     = 32,
  parameter int ADDR_W    = 12,
  parameter int LFSR_W    = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_en,
  input  logic [ACC_W-1:0]  step_word,
  input  logic              dither_en,
  output logic [ADDR_W-1:0] phase_q,
  output logic              valid_q
);
  localparam int SHIFT   = ACC_W - ADDR_W;
  localparam int DITH_SH = SHIFT - 3 - (LFSR_W - 1);
  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);

  logic [ACC_W-1:0]        acc_q, acc_d, rsum;
  logic [LFSR_W-1:0]       lfsr_state;
  logic signed [ACC_W-1:0] dith_ext, dith_val;
  logic [ADDR_W-1:0]       phase_d;

  dds_lfsr #(.WIDTH(LFSR_W), .SEED(LFSR_SEED)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .advance(sample_en), .state(lfsr_state)
  );

  assign dith_ext = {{(ACC_W-LFSR_W){lfsr_state[LFSR_W-1]}}, lfsr_state};

  generate
    if (DITH_SH >= 0) begin : g_dith_up
      assign dith_val = dith_ext <<< DITH_SH;
    end else begin : g_dith_down
      assign dith_val = dith_ext >>> (-DITH_SH);
    end
  endgenerate

  always_comb begin
    rsum    = acc_q + (dither_en ? dith_val : '0) + HALF;
    phase_d = ADDR_W'(rsum >> SHIFT);
    acc_d   = acc_q + step_word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q   <= '0;
      phase_q <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= sample_en;
      if (sample_en) begin
        acc_q   <= acc_d;
        phase_q <= phase_d;
      end
    end
  end
endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 14
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [OUT_W-1:0] val
);
  localparam int QBITS  = ADDR_W - 2;
  localparam int QDEPTH = 1 << QBITS;
  localparam int AMP    = (1 << (OUT_W - 1)) - 1;

  typedef logic [OUT_W-1:0] word_t;
  typedef word_t [QDEPTH:0] qtab_t;

  function automatic qtab_t build_qtab();
    qtab_t t;
    for (int k = 0; k <= QDEPTH; k++)
      t[k] = word_t'(dds_pkg::round_away(real'(AMP) *
             $sin(dds_pkg::TWO_PI * real'(k) / real'(4 * QDEPTH))));
    return t;
  endfunction

  localparam qtab_t QTAB = build_qtab();

  logic [1:0]       quad;
  logic [QBITS:0]   idx;
  logic signed [OUT_W-1:0] mag;

  always_comb begin
    quad = addr[ADDR_W-1:ADDR_W-2];
    idx  = {1'b0, addr[QBITS-1:0]};
    if (quad[0]) idx = (QBITS+1)'(QDEPTH) - idx;
    mag  = QTAB[idx];
    val  = quad[1] ? -mag : mag;
  end
endmodule

// File: rtl/dds_synth.sv
module dds_synth #(
  parameter int ACC_W  = 32,
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 14,
  parameter int LFSR_W = 16,
  parameter logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    sample_en,
  input  logic [ACC_W-1:0]        step_word,
  input  logic                    dither_en,
  output logic signed [OUT_W-1:0] cos_out,
  output logic signed [OUT_W-1:0] sin_out,
  output logic [ADDR_W-1:0]       phase_out,
  output logic                    out_valid
);
  localparam logic [ADDR_W-1:0] QUARTER = ADDR_W'(1) << (ADDR_W - 2);

  logic [ADDR_W-1:0]       phase_q;
  logic                    valid_q;
  logic [ADDR_W-1:0]       lut_addr [2];
  logic signed [OUT_W-1:0] lut_val  [2];
  logic signed [OUT_W-1:0] cos_d, sin_d;
  logic [ADDR_W-1:0]       phase_d;

  dds_phase_quant #(
    .ACC_W(ACC_W), .ADDR_W(ADDR_W), .LFSR_W(LFSR_W), .LFSR_SEED(LFSR_SEED)
  ) u_quant (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .step_word(step_word),
    .dither_en(dither_en), .phase_q(phase_q), .valid_q(valid_q)
  );

  // lane 0: sine at phase, lane 1: cosine as sine a quarter turn ahead
  generate
    for (genvar g = 0; g < 2; g++) begin : g_lane
      assign lut_addr[g] = phase_q + (g == 1 ? QUARTER : '0);
      dds_sine_rom #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_rom (
        .addr(lut_addr[g]), .val(lut_val[g])
      );
    end
  endgenerate

  always_comb begin
    sin_d   = sin_out;
    cos_d   = cos_out;
    phase_d = phase_out;
    if (valid_q) begin
      sin_d   = lut_val[0];
      cos_d   = lut_val[1];
      phase_d = phase_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cos_out   <= '0;
      sin_out   <= '0;
      phase_out <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= valid_q;
      cos_out   <= cos_d;
      sin_out   <= sin_d;
      phase_out <= phase_d;
    end
  end
endmodule

// File: rtl/dds_synth_chk.sv
module dds_synth_chk #(
  parameter int ADDR_W = 12,
  parameter int OUT_W  = 14
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    sample_en,
  input logic signed [OUT_W-1:0] cos_out,
  input logic signed [OUT_W-1:0] sin_out,
  input logic [ADDR_W-1:0]       phase_out,
  input logic                    out_valid
);
  localparam logic signed [OUT_W-1:0] MOST_NEG = {1'b1, {(OUT_W-1){1'b0}}};

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(rst_n, 2)) |-> (out_valid == $past(sample_en, 2))); // R7

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(cos_out) && $stable(sin_out) && $stable(phase_out))); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cos_out != MOST_NEG) && (sin_out != MOST_NEG)); // R9

  AST_SINE_POS_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sin_out > 0) |-> !phase_out[ADDR_W-1]); // R10

  AST_SINE_NEG_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && sin_out < 0) |-> phase_out[ADDR_W-1]); // R10

  AST_COS_POS_QUAD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cos_out > 0) |-> (phase_out[ADDR_W-1] == phase_out[ADDR_W-2])); // R10
endmodule

bind dds_synth dds_synth_chk #(.ADDR_W(ADDR_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .cos_out(cos_out),
  .sin_out(sin_out), .phase_out(phase_out), .out_valid(out_valid)
);

// File: tb/dds_synth_test.sv
module dds_synth_test;
  logic        clk, rst_n, sample_en, dither_en;
  logic [31:0] step_word;
  logic signed [13:0] cos_out, sin_out;
  logic [11:0] phase_out;
  logic        out_valid;

  int n_checks = 0, n_fail = 0, cycles = 0;

  dds_synth uut (
    .clk(clk), .rst_n(rst_n), .sample_en(sample_en), .step_word(step_word),
    .dither_en(dither_en), .cos_out(cos_out), .sin_out(sin_out),
    .phase_out(phase_out), .out_valid(out_valid)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // ---------------- behavioural reference ----------------
  longint m_acc;
  int     m_lfsr, m1_phase, m2_phase, m2_cos, m2_sin;
  bit     m1_v, m2_v;

  function automatic int ref_wave(int p, bit want_cos);
    real x = want_cos ? 8191.0 * $cos(6.283185307179586 * p / 4096.0)
                      : 8191.0 * $sin(6.283185307179586 * p / 4096.0);
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(0.5 - x);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_acc = 0; m_lfsr = 'hACE1; m1_v = 0; m2_v = 0;
      m1_phase = 0; m2_phase = 0; m2_cos = 0; m2_sin = 0;
    end else begin
      if (m1_v) begin
        m2_phase = m1_phase;
        m2_cos = ref_wave(m1_phase, 1);
        m2_sin = ref_wave(m1_phase, 0);
      end
      m2_v = m1_v;
      m1_v = sample_en;
      if (sample_en) begin
        longint d, s;
        int sv, fb;
        sv = (m_lfsr >= 32768) ? m_lfsr - 65536 : m_lfsr;
        d  = dither_en ? longint'(sv) * 4 : 0;
        s  = (m_acc + d + 524288) & 64'hFFFF_FFFF;
        m1_phase = int'((s >> 20) & 4095);
        m_acc = (m_acc + longint'(step_word)) & 64'hFFFF_FFFF;
        fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
        m_lfsr = ((m_lfsr << 1) | fb) & 'hFFFF;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      check("R7 valid", int'(out_valid), int'(m2_v));
      check("R4/R5/R8 phase", int'(phase_out), m2_phase);
      check("R6/R8 cos", int'(cos_out), m2_cos);
      check("R6/R8 sin", int'(sin_out), m2_sin);
    end
  end

  task automatic do_reset();
    rst_n = 1'b0; sample_en = 1'b0; dither_en = 1'b0; step_word = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // one strobe, then sample the result two clocks later
  task automatic one_sample(input logic [31:0] step);
    step_word = step; sample_en = 1'b1;
    @(negedge clk); sample_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic run(int n, int gap, logic [31:0] step, bit dith, bit toggle_dith);
    step_word = step; dither_en = dith;
    for (int i = 0; i < n; i++) begin
      sample_en = 1'b1;
      if (toggle_dith) dither_en = i[2];
      @(negedge clk);
      sample_en = 1'b0;
      for (int g = 0; g < gap; g++) @(negedge clk);
    end
    sample_en = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sample_en = 1'b0; dither_en = 1'b0; step_word = '0;
    @(negedge clk);
    check("R1 reset valid", int'(out_valid), 0);
    check("R1 reset cos", int'(cos_out), 0);
    check("R1 reset sin", int'(sin_out), 0);
    check("R1 reset phase", int'(phase_out), 0);
    do_reset();
    check("R1 idle valid", int'(out_valid), 0);

    // R3: first sample is phase zero; R4 half-LSB step rounds up next
    one_sample(32'h0008_0000);
    check("R3 first phase", int'(phase_out), 0);
    check("R3 first cos", int'(cos_out), 8191);
    check("R3 first sin", int'(sin_out), 0);
    check("R7 pulse", int'(out_valid), 1);
    @(negedge clk);
    check("R7 single pulse", int'(out_valid), 0);
    one_sample(32'h0008_0000);
    check("R4 round half up", int'(phase_out), 1);
    // R2: idle clocks leave the accumulator alone
    repeat (5) @(negedge clk);
    one_sample(32'h0);
    check("R2 accumulate 2*half", int'(phase_out), 1);
    one_sample(32'h0);
    check("R2 zero step holds", int'(phase_out), 1);

    // R4: top address rounds up and wraps to zero
    do_reset();
    one_sample(32'hFFF8_0000);
    one_sample(32'h0);
    check("R4 top wrap", int'(phase_out), 0);
    check("R6 wrap cos", int'(cos_out), 8191);

    // R2 modulo wrap of the accumulator, sparse strobes
    do_reset();
    run(40, 2, 32'h9234_5678, 1'b0, 1'b0);
    // R5 dither with continuous strobes and a toggled enable
    do_reset();
    run(300, 0, 32'd1252698795, 1'b1, 1'b0);
    run(200, 1, 32'h0123_4567, 1'b0, 1'b1);
    // R6: every table phase
    do_reset();
    run(4100, 0, 32'h0010_0000, 1'b0, 1'b0);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=%0d expected<=100000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
      end
    end
  end
endmodule